// File: doc/BRIEF.md
# Gated Fetch Decryption Window Controller

This block sits on the read path between a 68000-style bus master and its program ROM. For each read it decides whether the word coming back from memory goes through a keyed decryption transform or is returned untouched. Three things must all be true for decryption to apply:

- the function code marks the read as a program-space fetch;
- the byte address lies below a configurable window limit;
- an internal enable timer is still running.

The enable timer is reloaded only when a programmed run of instruction words is seen on program fetches. It counts down on every clock and turns decryption off when it reaches zero. After reset it starts expired.

The transform is a placeholder cipher. The word is XORed with a key derived from address bits 16..1, and the result passes through a fixed bit permutation. The mapping therefore repeats every 128 KB, and for any address it is one-to-one over all 16-bit words. The data path is combinational. The timer and the trigger matcher update on the clock edge that ends a read.

Top module: `fetch_crypt_gate`

## Requirements
- R1: Only function codes 2 (user program) and 6 (supervisor program) can be decrypted. With any other function code, rdata_o equals rdata_i.
- R2: A program fetch is decrypted only when its byte address {addr_i,0} is below WIN_BYTES (default 1 MB). At or above that limit, rdata_o equals rdata_i.
- R3: Once a trigger completes at a clock edge, dec_en_o is high for exactly RELOAD clock periods and then goes low. While dec_en_o is low, every read is returned raw.
- R4: After reset, dec_en_o is low and program fetches inside the window return raw data.
- R5: The trigger fires when TRIG_LEN consecutive program fetches deliver words (as seen on rdata_o) equal to TRIG_WORDS[15:0], [31:16], and onward in that order. Firing reloads the timer whether it has expired or is still running.
- R6: A program fetch whose delivered word does not equal the expected trigger word returns the matcher to its start state. Data-space reads and idle cycles leave the matcher unchanged.
- R7: The transform depends only on addr_i[16:1]. Addresses that differ by a multiple of 128 KB give the same output.
- R8: The transform is computed as follows. Let a = addr_i[16:1] and key = {a[10:0],a[15:11]} ^ KEY_SEED. Let v = rdata_i ^ key. Then rdata_o[i] = v[(i*PERM_STEP+PERM_OFS) mod 16]. With an odd PERM_STEP this is one-to-one over all 16-bit inputs.
- R9: dec_active_o is high exactly on those reads where the transform is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | A read is on the bus this cycle |
| fc_i | input | 3 | Function code of the read |
| addr_i | input | ADDR_W-1 | Word address, bits ADDR_W-1..1 |
| rdata_i | input | 16 | Raw word from ROM |
| rdata_o | output | 16 | Word delivered to the master |
| dec_active_o | output | 1 | Transform applied to this read |
| dec_en_o | output | 1 | Enable timer running |

## Verification
The bench measures the enable window to the exact cycle, both from an expired timer and after a re-arm in mid-count. A timer that is off by one cycle, or that ignores a trigger arriving while it is still running, therefore shows up as a wrong count.

It sweeps every function code and probes both sides of the window limit. A decoder that treats data space as program space, or that compares the limit with the wrong inequality, would decrypt words that must come back raw.

Broken trigger runs are also driven. One run is interrupted by a wrong program word, which a matcher that fails to reset would accept. Another is interleaved with data reads and idle cycles, which a matcher that resets on those would reject.

Finally, every 16-bit input is pushed through the transform at one address and inverted in the bench. A permutation that merges two bit positions would fail this round trip.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int WORD_W = 16;
  localparam int MAX_TRIG = 4;

  typedef enum logic [2:0] {
    FC_USER_DATA = 3'd1,
    FC_USER_PROG = 3'd2,
    FC_SUP_DATA  = 3'd5,
    FC_SUP_PROG  = 3'd6
  } fc_e;

  function automatic logic is_prog(input logic [2:0] fc);
    return (fc == FC_USER_PROG) || (fc == FC_SUP_PROG);
  endfunction
endpackage

// File: rtl/fcg_xform.sv
module fcg_xform #(
  parameter logic [15:0] KEY_SEED  = 16'hA5C3,
  parameter int          PERM_STEP = 5,
  parameter int          PERM_OFS  = 3
) (
  input  logic [15:0] idx_i,
  input  logic [15:0] d_i,
  output logic [15:0] d_o
);
  logic [15:0] key;
  logic [15:0] mixed;

  assign key   = {idx_i[10:0], idx_i[15:11]} ^ KEY_SEED;
  assign mixed = d_i ^ key;

  // odd step keeps the bit map a permutation of 16 positions
  for (genvar i = 0; i < 16; i++) begin : g_perm
    localparam int SRC = (i * PERM_STEP + PERM_OFS) % 16;
    assign d_o[i] = mixed[SRC];
  end
endmodule

// File: rtl/fcg_trig_match.sv
module fcg_trig_match #(
  parameter int                TRIG_LEN   = 2,
  parameter logic [4*16-1:0]   TRIG_WORDS = 64'h0000_0000_4E71_4EF9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  input  logic [15:0] word_i,
  output logic        hit_o
);
  logic [1:0]  idx_q, idx_d;
  logic [15:0] want;
  logic        match;

  assign want  = TRIG_WORDS[idx_q*16 +: 16];
  assign match = (word_i == want);
  assign hit_o = step_i && match && (idx_q == 2'(TRIG_LEN - 1));

  always_comb begin
    idx_d = idx_q;
    if (step_i) begin
      if (!match || hit_o) idx_d = '0;
      else                 idx_d = idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end
endmodule

// File: rtl/fcg_timer.sv
module fcg_timer #(
  parameter int RELOAD = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic en_o
);
  localparam int CW = $clog2(RELOAD + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(RELOAD);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign en_o = (cnt_q != '0);
endmodule

// File: rtl/fetch_crypt_gate.sv
module fetch_crypt_gate
  import fcg_pkg::*;
#(
  parameter int              ADDR_W     = 24,
  parameter int              ROM_BYTES  = 4 * 1024 * 1024,
  parameter int              WIN_BYTES  = 1024 * 1024,
  parameter int              RELOAD     = 1024,
  parameter int              TRIG_LEN   = 2,
  parameter logic [4*16-1:0] TRIG_WORDS = 64'h0000_0000_4E71_4EF9,
  parameter logic [15:0]     KEY_SEED   = 16'hA5C3,
  parameter int              PERM_STEP  = 5,
  parameter int              PERM_OFS   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [2:0]        fc_i,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic [15:0]       rdata_i,
  output logic [15:0]       rdata_o,
  output logic              dec_active_o,
  output logic              dec_en_o
);
  localparam int WIN_EFF = (WIN_BYTES < ROM_BYTES) ? WIN_BYTES : ROM_BYTES;
  localparam logic [ADDR_W:0] WIN_LIM = (ADDR_W + 1)'(WIN_EFF);

  logic [ADDR_W:0] byte_addr;
  logic            in_win;
  logic            prog_rd;
  logic [15:0]     dec_word;
  logic            trig_hit;

  assign byte_addr = {1'b0, addr_i, 1'b0};
  assign in_win    = byte_addr < WIN_LIM;
  assign prog_rd   = rd_valid_i && is_prog(fc_i);

  fcg_xform #(
    .KEY_SEED (KEY_SEED),
    .PERM_STEP(PERM_STEP),
    .PERM_OFS (PERM_OFS)
  ) u_xform (
    .idx_i(addr_i[16:1]),
    .d_i  (rdata_i),
    .d_o  (dec_word)
  );

  assign dec_active_o = prog_rd && in_win && dec_en_o;
  assign rdata_o      = dec_active_o ? dec_word : rdata_i;

  // trigger compares the word the master actually receives
  fcg_trig_match #(
    .TRIG_LEN  (TRIG_LEN),
    .TRIG_WORDS(TRIG_WORDS)
  ) u_match (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(prog_rd),
    .word_i(rdata_o),
    .hit_o (trig_hit)
  );

  fcg_timer #(
    .RELOAD(RELOAD)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(trig_hit),
    .en_o  (dec_en_o)
  );
endmodule

// File: rtl/fetch_crypt_gate_chk.sv
module fetch_crypt_gate_chk
  import fcg_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int WIN_BYTES = 1024 * 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_valid_i,
  input logic [2:0]        fc_i,
  input logic [ADDR_W-1:1] addr_i,
  input logic [15:0]       rdata_i,
  input logic [15:0]       rdata_o,
  input logic              dec_active_o,
  input logic              dec_en_o
);
  logic [ADDR_W:0] ba;
  assign ba = {1'b0, addr_i, 1'b0};

  // R1
  data_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !is_prog(fc_i)) |-> (rdata_o == rdata_i));

  // R2
  win_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && (ba >= (ADDR_W + 1)'(WIN_BYTES))) |-> (rdata_o == rdata_i));

  // R3
  off_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_en_o |-> (!dec_active_o && rdata_o == rdata_i));

  // R5
  rise_after_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dec_en_o) |-> $past(rd_valid_i && is_prog(fc_i)));

  // R9
  active_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_active_o |-> (dec_en_o && rd_valid_i && is_prog(fc_i)));
endmodule

bind fetch_crypt_gate fetch_crypt_gate_chk #(
  .ADDR_W   (ADDR_W),
  .WIN_BYTES(WIN_BYTES)
) u_chk (.*);

// File: tb/fetch_crypt_gate_tb.sv
module fetch_crypt_gate_tb;
  localparam int              AW     = 24;
  localparam int              RELOAD = 64;
  localparam int              WIN    = 1024 * 1024;
  localparam logic [15:0]     SEED   = 16'hA5C3;
  localparam logic [15:0]     W0 = 16'h4EF9, W1 = 16'h13FC, W2 = 16'h4E71;
  localparam logic [4*16-1:0] TW = {16'h0000, W2, W1, W0};

  logic              clk = 0;
  logic              rst_n = 0;
  logic              rd_valid = 0;
  logic [2:0]        fc = 0;
  logic [AW-1:1]     addr = '0;
  logic [15:0]       rdata = 0;
  logic [15:0]       q;
  logic              act, en;
  logic [15:0]       xf_idx = 0, xf_in = 0, xf_out;

  int tests = 0;
  int fails = 0;
  logic [15:0] got;
  logic        got_act;

  always #10 clk = ~clk;

  fetch_crypt_gate #(
    .ADDR_W(AW), .WIN_BYTES(WIN), .RELOAD(RELOAD), .TRIG_LEN(3),
    .TRIG_WORDS(TW), .KEY_SEED(SEED), .PERM_STEP(5), .PERM_OFS(3)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_valid_i(rd_valid), .fc_i(fc),
    .addr_i(addr), .rdata_i(rdata), .rdata_o(q), .dec_active_o(act),
    .dec_en_o(en)
  );

  fcg_xform #(.KEY_SEED(SEED), .PERM_STEP(5), .PERM_OFS(3)) u_xf (
    .idx_i(xf_idx), .d_i(xf_in), .d_o(xf_out)
  );

  function automatic logic [15:0] key_of(input logic [23:0] ba);
    logic [15:0] a;
    a = ba[16:1];
    return {a[10:0], a[15:11]} ^ SEED;
  endfunction

  function automatic logic [15:0] enc(input logic [15:0] x, input logic [23:0] ba);
    logic [15:0] v, y;
    v = x ^ key_of(ba);
    for (int i = 0; i < 16; i++) y[i] = v[(i * 5 + 3) % 16];
    return y;
  endfunction

  function automatic logic [15:0] dec(input logic [15:0] y, input logic [23:0] ba);
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[(i * 5 + 3) % 16] = y[i];
    return v ^ key_of(ba);
  endfunction

  task automatic check(input string req, input logic [15:0] a, input logic [15:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, a, e);
    end
  endtask

  task automatic rd(input logic [2:0] f, input logic [23:0] ba, input logic [15:0] d);
    @(negedge clk);
    rd_valid = 1; fc = f; addr = ba[23:1]; rdata = d;
    #1;
    got = q; got_act = act;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_valid = 0;
    #1;
  endtask

  task automatic fire(input logic [23:0] base);
    rd(3'd6, base, W0);
    rd(3'd2, base + 2, W1);
    rd(3'd6, base + 4, W2);
    idle();
  endtask

  task automatic count_on(output int n);
    n = 0;
    while (en && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] y0;
    logic [23:0] oa;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R4 reset state
    #1;
    check("R4 enable after reset", {15'd0, en}, 16'd0);
    rd(3'd6, 24'h000100, 16'hBEEF);
    check("R4 raw fetch after reset", got, 16'hBEEF);
    idle();

    // R5 trigger from expired, R3 exact window
    fire(24'h200000);
    count_on(n);
    check("R3 enable length from expiry", 16'(n), 16'(RELOAD));

    // R5 re-arm while running
    fire(24'h200000);
    repeat (20) idle();
    fire(24'h200100);
    count_on(n);
    check("R5 re-arm mid-count length", 16'(n), 16'(RELOAD));

    // R1 R2 R8 R9 while enabled
    fire(24'h200000);
    for (int f = 0; f < 8; f++) begin
      rd(3'(f), 24'h001234, 16'h5A3C);
      if (f == 2 || f == 6) begin
        check("R1 program fc decrypted", got, enc(16'h5A3C, 24'h001234));
        check("R9 active on decrypt", {15'd0, got_act}, 16'd1);
      end else begin
        check("R1 non-program fc raw", got, 16'h5A3C);
        check("R9 inactive on raw", {15'd0, got_act}, 16'd0);
      end
    end
    rd(3'd6, WIN - 2, 16'h0F0F);
    check("R2 last word inside window", got, enc(16'h0F0F, WIN - 2));
    rd(3'd6, WIN, 16'h0F0F);
    check("R2 first word outside window", got, 16'h0F0F);
    rd(3'd2, 24'h3FFFFE, 16'h7777);
    check("R2 top of ROM raw", got, 16'h7777);
    for (int k = 0; k < 12; k++) begin
      oa = 24'(k * 24'h00A3F6) & 24'h0FFFFE;
      rd(3'd2, oa, 16'(k * 16'h1F3B));
      check("R8 transform model", got, enc(16'(k * 16'h1F3B), oa));
    end
    // R7 128K wrap
    rd(3'd6, 24'h004560, 16'hC0DE);
    y0 = got;
    rd(3'd6, 24'h064560, 16'hC0DE);
    check("R7 wrap at 128K", got, y0);
    idle();

    // R3 expiry returns raw
    count_on(n);
    rd(3'd6, 24'h001234, 16'h5A3C);
    check("R3 raw after expiry", got, 16'h5A3C);
    idle();

    // R6 wrong word breaks the run
    rd(3'd6, 24'h200000, W0);
    rd(3'd6, 24'h200002, W1);
    rd(3'd6, 24'h200004, 16'h1234);
    rd(3'd6, 24'h200006, W2);
    idle();
    check("R6 mismatch resets matcher", {15'd0, en}, 16'd0);

    // R6 data reads and idles do not disturb
    rd(3'd6, 24'h200000, W0);
    rd(3'd5, 24'h200002, 16'h1234);
    rd(3'd1, 24'h200002, W2);
    idle();
    rd(3'd2, 24'h200004, W1);
    idle();
    idle();
    rd(3'd6, 24'h200006, W2);
    idle();
    check("R6 data reads ignored by matcher", {15'd0, en}, 16'd1);

    // R5 trigger delivered through decryption
    count_on(n);
    fire(24'h200000);
    rd(3'd6, 24'h000010, dec(W0, 24'h000010));
    rd(3'd6, 24'h000012, dec(W1, 24'h000012));
    repeat (5) idle();
    rd(3'd6, 24'h000014, dec(W2, 24'h000014));
    idle();
    count_on(n);
    check("R5 trigger on decrypted words", 16'(n), 16'(RELOAD));

    // R8 one-to-one sweep at one address
    begin
      int bad = 0;
      logic [15:0] fa, fe;
      xf_idx = 16'h3A5C;
      for (int x = 0; x < 65536; x++) begin
        xf_in = 16'(x);
        #1;
        if (bad == 0 && (xf_out !== enc(16'(x), {7'd0, xf_idx, 1'b0}) ||
                         dec(xf_out, {7'd0, xf_idx, 1'b0}) !== 16'(x))) begin
          bad = 1; fa = xf_out; fe = enc(16'(x), {7'd0, xf_idx, 1'b0});
        end
      end
      if (bad != 0) check("R8 bijective sweep", fa, fe);
      else          check("R8 bijective sweep", 16'd0, 16'd0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule